// File: doc/BRIEF.md
# Triggered Delay Timer with Debounce Mode

This block turns an asynchronous trigger into a single-cycle `done` pulse that appears a fixed number of clock cycles after the trigger rises. It runs from a 50 MHz system clock. With the default parameters the delay is 10 ms, which is 500,000 cycles. The raw trigger first passes through a two-flop synchronizer. An edge detector then starts the delay, and a prescaler feeding a short main counter measures it. The cascade keeps each terminal-count compare narrow.

A static select input chooses one of two behaviours. In one-shot mode a started delay always runs to the end, whatever the trigger does. In debounce mode the trigger has to stay high for the whole delay. If it drops early, both counters go back to zero and no pulse is produced. The `busy` output marks a running delay. A synchronous active-high reset clears everything.

Top module: `trig_delay_timer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy` and `done` are 0 and both counters are cleared. A trigger edge after reset produces a full-length delay.
- R2: `done` is high for exactly one clock cycle per completed delay. A trigger that stays high after the pulse produces no further pulse.
- R3: A completed delay keeps `busy` high for exactly TICK_DIV*TICK_COUNT cycles. `done` rises in the cycle in which `busy` falls.
- R4: With `mode_sel`=0 (one-shot), trigger changes during a running delay are ignored. The run still lasts TICK_DIV*TICK_COUNT cycles and ends with one `done` pulse.
- R5: With `mode_sel`=1 (debounce), a trigger that falls during a run ends it without a `done` pulse. `busy` is still high after the second rising edge that follows the fall and is low after the third.
- R6: In debounce mode, a new rising edge after an aborted run starts a full-length delay from zero.
- R7: In debounce mode, if the release reaches the control logic in the same cycle as the terminal count, no pulse is produced. A release one cycle later still gives a pulse.
- R8: A delay starts only on a rising edge of the synchronized trigger seen while idle. `busy` is low after the second rising clock edge that follows the raw rise and high after the third.
- R9: Asserting `rst` during a run ends it with no `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_async | input | 1 | Raw trigger, asynchronous to `clk` |
| mode_sel | input | 1 | 0 = one-shot, 1 = debounce; held static outside reset |
| done | output | 1 | Single-cycle pulse at the end of a completed delay |
| busy | output | 1 | High while a delay is running |

## Verification
Two events can fall in the same cycle: the terminal count that would finish a delay, and a debounce release that clears the counters. The bench provokes this by lowering the raw trigger exactly TICK_DIV*TICK_COUNT cycles after raising it. It expects no pulse in that case. A second run releases one cycle later and expects a pulse. Random trigger waveforms in both modes are compared cycle by cycle against a model of elapsed cycles. That model covers releases arriving near the end of a run and rising edges arriving during a run.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  typedef enum logic {
    TDT_ONESHOT  = 1'b0,
    TDT_DEBOUNCE = 1'b1
  } tdt_mode_e;
endpackage

// File: rtl/tdt_sync.sv
// Multi-flop synchronizer for one asynchronous level.
module tdt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tdt_prescale.sv
// Prescaler: emits one enable tick every DIV running cycles.
module tdt_prescale #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (run)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  // R3: the prescale count never passes its terminal value
  a_r3_pre_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/tdt_mainctr.sv
// Main counter: advances once per prescaler tick and flags its last step.
module tdt_mainctr #(
  parameter int TERM = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic last
);
  localparam int W = $clog2(TERM + 1);
  localparam logic [W-1:0] LASTV = W'(TERM - 1);

  logic [W-1:0] cnt;

  assign last = (cnt == LASTV);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (adv)   cnt <= (cnt == LASTV) ? '0 : cnt + 1'b1;
  end

  // R3: the main count never passes its terminal value
  a_r3_main_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LASTV);
endmodule

// File: rtl/trig_delay_timer.sv
// Triggered delay timer: synchronizer, edge detect, cascaded counters,
// registered done/busy.
module trig_delay_timer
  import tdt_pkg::*;
#(
  parameter int TICK_DIV    = 50000,
  parameter int TICK_COUNT  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_async,
  input  logic mode_sel,
  output logic done,
  output logic busy
);
  tdt_mode_e mode;
  logic trig_s, trig_d, rise;
  logic busy_q, done_q;
  logic abort, fin, tick, main_last, cnt_clr;

  assign mode = tdt_mode_e'(mode_sel);

  tdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(trig_async), .q(trig_s)
  );

  assign rise    = trig_s && !trig_d;
  assign abort   = busy_q && (mode == TDT_DEBOUNCE) && !trig_s;
  assign cnt_clr = !busy_q || abort;

  tdt_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .clr(cnt_clr), .run(busy_q), .tick(tick)
  );

  tdt_mainctr #(.TERM(TICK_COUNT)) u_main (
    .clk(clk), .rst(rst), .clr(cnt_clr), .adv(tick), .last(main_last)
  );

  // terminal compare, qualified by the absence of a clear this cycle
  assign fin = busy_q && tick && main_last && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_d <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      trig_d <= trig_s;
      done_q <= fin;
      if (!busy_q && rise)  busy_q <= 1'b1;
      else if (abort || fin) busy_q <= 1'b0;
    end
  end

  assign done = done_q;
  assign busy = busy_q;

  // R1: outputs are idle in the cycle after reset
  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      a_r1_reset_idle: assert (!busy_q && !done_q)
        else $error("a_r1_reset_idle");
    end
  end

  // R2: done lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R3: done only as a run ends
  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(busy_q) && !busy_q));

  // R4: in one-shot mode every run that ends outside reset ends with done
  a_r4_oneshot_completes: assert property (@(posedge clk) disable iff (rst)
    ((mode == TDT_ONESHOT) && $fell(busy_q) && !$past(rst)) |-> done_q);

  // R5, R7: a debounce release ends the run without a pulse
  a_r5_release_aborts: assert property (@(posedge clk) disable iff (rst)
    (busy_q && (mode == TDT_DEBOUNCE) && !trig_s) |=> (!busy_q && !done_q));
endmodule

// File: tb/test_trig_delay_timer.sv
module test_trig_delay_timer;
  localparam int P = 4;
  localparam int T = 3;
  localparam int N = P * T;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_async = 1'b0;
  logic mode_sel = 1'b0;
  logic done, busy;

  int n_chk = 0;
  int n_fail = 0;

  trig_delay_timer #(.TICK_DIV(P), .TICK_COUNT(T), .SYNC_STAGES(2)) i_trig_delay_timer (
    .clk(clk), .rst(rst), .trig_async(trig_async), .mode_sel(mode_sel),
    .done(done), .busy(busy)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len();
    return N;
  endfunction

  // Reference model in terms of elapsed cycles since start
  logic m_s1 = 0, m_s2 = 0, m_d = 0, m_busy = 0, m_done = 0;
  int   m_cnt = 0;
  logic seen_rst = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_d <= 0; m_busy <= 0; m_done <= 0; m_cnt <= 0;
      seen_rst <= 1;
    end else begin
      m_s1 <= trig_async; m_s2 <= m_s1; m_d <= m_s2;
      m_done <= 0;
      if (!m_busy) begin
        if (m_s2 && !m_d) begin m_busy <= 1; m_cnt <= 0; end
      end else if (mode_sel && !m_s2) begin
        m_busy <= 0;
      end else if (m_cnt == exp_len() - 1) begin
        m_busy <= 0; m_done <= 1;
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  int busy_seen = 0, done_seen = 0;
  always @(negedge clk) begin
    if (!rst && seen_rst) begin
      if (busy) busy_seen++;
      if (done) done_seen++;
      check("R2 model done", int'(done), int'(m_done));
      check(mode_sel ? "R5 model busy" : "R4 model busy", int'(busy), int'(m_busy));
    end
  end

  task automatic tick_n(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic clr_obs();
    busy_seen = 0; done_seen = 0;
  endtask

  task automatic do_reset(input logic m);
    rst = 1; trig_async = 0; mode_sel = m;
    tick_n(3);
    rst = 0;
    tick_n(4);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    tick_n(2);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    rst = 0;
    tick_n(1);
    check("R1 busy after reset", int'(busy), 0);
    tick_n(3);

    // R8 start latency, then R3/R2 full one-shot run with trigger held high
    clr_obs();
    trig_async = 1;
    tick_n(1); check("R8 busy after edge 1", int'(busy), 0);
    tick_n(1); check("R8 busy after edge 2", int'(busy), 0);
    tick_n(1); check("R8 busy after edge 3", int'(busy), 1);
    tick_n(N + 10);
    check("R3 busy length", busy_seen, N);
    check("R2 one pulse, trigger held", done_seen, 1);
    trig_async = 0;
    tick_n(4);

    // R4 one-shot ignores toggles during run
    clr_obs();
    trig_async = 1;
    tick_n(3);
    for (int i = 0; i < N - 4; i++) begin
      trig_async = ~trig_async;
      tick_n(1);
    end
    trig_async = 0;
    tick_n(N);
    check("R4 busy length with toggles", busy_seen, N);
    check("R4 one pulse with toggles", done_seen, 1);

    // R5 debounce release aborts
    do_reset(1'b1);
    clr_obs();
    trig_async = 1;
    tick_n(3 + 4);
    trig_async = 0;
    tick_n(2); check("R5 busy one edge pending", int'(busy), 1);
    tick_n(1); check("R5 busy after abort", int'(busy), 0);
    tick_n(N);
    check("R5 no pulse after release", done_seen, 0);

    // R6 restart gives full delay
    clr_obs();
    trig_async = 1;
    tick_n(N + 8);
    check("R6 busy length after restart", busy_seen, N);
    check("R6 pulse after restart", done_seen, 1);
    trig_async = 0;
    tick_n(4);

    // R7 collision: release meets terminal count
    clr_obs();
    trig_async = 1;
    tick_n(N);
    trig_async = 0;
    tick_n(N);
    check("R7 no pulse on collision", done_seen, 0);
    check("R7 busy length on collision", busy_seen, N);
    clr_obs();
    trig_async = 1;
    tick_n(N + 1);
    trig_async = 0;
    tick_n(N);
    check("R7 pulse when release one cycle late", done_seen, 1);

    // R9 reset mid-run
    do_reset(1'b0);
    trig_async = 1;
    tick_n(6);
    check("R9 running before reset", int'(busy), 1);
    rst = 1; trig_async = 0;
    tick_n(1);
    rst = 0;
    clr_obs();
    tick_n(1);
    check("R9 busy after reset", int'(busy), 0);
    tick_n(N + 4);
    check("R9 no pulse after reset", done_seen, 0);
    check("R1 stays idle after reset", busy_seen, 0);

    // Random phase, both modes, model compared each cycle
    for (int m = 0; m < 2; m++) begin
      do_reset(logic'(m));
      for (int k = 0; k < 400; k++) begin
        trig_async = logic'($urandom_range(0, 1));
        tick_n($urandom_range(1, 2 * N));
      end
      trig_async = 0;
      tick_n(N + 6);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule